// File: doc/BRIEF.md
# Indexed-Colour Display Register File

This block is the processor-facing register file of an indexed-colour display controller. A simple request port carries 32-bit word accesses: a valid strobe, a write flag, a byte address and write data. Through it software sets the visible screen geometry, a control word, the base of the visible frame in video memory and the cursor position. It also loads three lookup tables: the 256-entry colour palette, a 3-entry cursor palette and a 512-word cursor pattern. The block presents the decoded configuration and combinational table lookups to the pixel pipeline. Every request is acknowledged on the following cycle, and read data comes back with that acknowledgement.

The geometry registers are stored in scaled units: the horizontal register is written in groups of four pixels, and the vertical register is written in half-lines. Table entries sit at an 8-byte stride, so the entry number is the offset from the table base shifted right by three. The interrupt line is raised by the pixel pipeline at the end of each refreshed frame and is dropped by any write. A write to one dedicated address returns all configuration and tables to zero.

Top module: `dispctl_regs`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_ready` high on the next cycle, and `rsp_ready` is low otherwise. A write's response carries `rsp_rdata` = 0.
- R2: A write of v to 0x000100 sets `cfg_width` to (v*4) mod 2^WID_W. A read of 0x000100 returns `cfg_width`/4.
- R3: A write of v to 0x000108 sets `cfg_height` to (v/2) mod 2^HGT_W. A read of 0x000108 returns `cfg_height`*2.
- R4: A write to 0x000110 stores a 32-bit control word that reads back unchanged. Bit 10 drives `cfg_blank`, and bit 23 set clears `cfg_cursor_on`.
- R5: Control bits 22:20 are a depth code. Codes 0 to 5 give `cfg_depth_bits` = 1, 2, 4, 8, 15 and 16 with `cfg_depth_ok` = 1. Codes 6 and 7 give 0 with `cfg_depth_ok` = 0.
- R6: A write to 0x000118 loads `cfg_top` from data bits TOP_W-1:0. A write to 0x000120 sets `cursor_x` from bits 23:12 and `cursor_y` from bits 11:0. Both of these addresses read as 0.
- R7: The colour palette starts at 0x000800 and has 256 entries. Entry = (addr-0x000800)>>3, so the low 3 address bits do not matter. Data packs red in 23:16, green in 15:8 and blue in 7:0, and appears on `pix_rgb` for `pix_index`. Bus reads of the colour palette return 0.
- R8: The cursor palette starts at 0x000400 and has 3 entries at the same stride and packing. It reads back over the bus and drives `cur_rgb` for `cur_sel`.
- R9: The cursor pattern starts at 0x001000 and has 512 16-bit words at the same stride, taken from data bits 15:0. It reads back zero-extended and drives `pat_word` for `pat_row`.
- R10: `frame_done` raises `irq` on the next cycle. Any write lowers it on the next cycle, and a write wins over a simultaneous `frame_done`.
- R11: A write to 0x100000 clears width, height, control, top, cursor position, all three tables and `irq`.
- R12: Writes to 0x000000–0x0000FF, and to any other unmapped address, change nothing. Reads of unmapped addresses return 0.
- R13: After reset all outputs are 0, except the depth outputs, which reflect code 0 (1 bit, valid), and `cfg_cursor_on`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 32 | Write data |
| frame_done | input | 1 | End-of-frame pulse from the pixel pipeline |
| rsp_ready | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready |
| irq | output | 1 | Frame interrupt request |
| cfg_width | output | WID_W | Visible width in pixels |
| cfg_height | output | HGT_W | Visible height in lines |
| cfg_top | output | TOP_W | Frame base address in video memory |
| cfg_blank | output | 1 | Force blank |
| cfg_cursor_on | output | 1 | Cursor enabled |
| cfg_depth_bits | output | 5 | Pixel depth in bits, 0 if unsupported |
| cfg_depth_ok | output | 1 | Depth code supported |
| cursor_x | output | COORD_W | Cursor x coordinate |
| cursor_y | output | COORD_W | Cursor y coordinate |
| pix_index | input | log2(PAL_N) | Colour palette lookup index |
| pix_rgb | output | 24 | Colour palette lookup result |
| cur_sel | input | log2(CPAL_N) | Cursor palette lookup index |
| cur_rgb | output | 24 | Cursor palette lookup result |
| pat_row | input | log2(PAT_N) | Cursor pattern lookup index |
| pat_word | output | PAT_W | Cursor pattern lookup result |

## Verification
Some properties are checked on every cycle: the one-cycle response, zero data on write responses, interrupt set and clear with clear priority, the scaling of a width write, the full clear after a soft reset, and the agreement between the depth outputs. The bench scenarios are needed for the rest. They cover the stride-based entry mapping, with sweeps over every palette and pattern entry. They also cover readback scaling of both geometry registers, truncation at the register width, and the write-only locations that read as zero. Finally, they check that writes to the ignored timing block and to unmapped space leave every observable output unchanged.

// File: rtl/dispctl_pkg.sv
// Shared address map, control-bit positions and region codes for the
// display register file. Assumes byte addresses on a 21-bit bus.
package dispctl_pkg;
    localparam int ADDR_W = 21;

    localparam logic [ADDR_W-1:0] A_HSIZE = 21'h000100;
    localparam logic [ADDR_W-1:0] A_VSIZE = 21'h000108;
    localparam logic [ADDR_W-1:0] A_CTRL  = 21'h000110;
    localparam logic [ADDR_W-1:0] A_TOP   = 21'h000118;
    localparam logic [ADDR_W-1:0] A_CPOS  = 21'h000120;
    localparam logic [ADDR_W-1:0] A_CPAL  = 21'h000400;
    localparam logic [ADDR_W-1:0] A_PAL   = 21'h000800;
    localparam logic [ADDR_W-1:0] A_PAT   = 21'h001000;
    localparam logic [ADDR_W-1:0] A_SRST  = 21'h100000;

    localparam int CTL_BLANK = 10;
    localparam int CTL_NOCUR = 23;
    localparam int CTL_DEPTH = 20;

    typedef enum logic [3:0] {
        RG_NONE, RG_HSIZE, RG_VSIZE, RG_CTRL, RG_TOP,
        RG_CPOS, RG_CPAL, RG_PAL, RG_PAT, RG_SRST
    } region_t;
endpackage

// File: rtl/dispctl_decode.sv
// Address decoder: maps a byte address to a region and, for tables, to an
// entry index at an 8-byte stride. Assumes regions do not overlap.
module dispctl_decode
    import dispctl_pkg::*;
#(
    parameter int CPAL_N = 3,
    parameter int PAL_N  = 256,
    parameter int PAT_N  = 512,
    parameter int IDX_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] CPAL_END = A_CPAL + ADDR_W'(CPAL_N * 8);
    localparam logic [ADDR_W-1:0] PAL_END  = A_PAL  + ADDR_W'(PAL_N * 8);
    localparam logic [ADDR_W-1:0] PAT_END  = A_PAT  + ADDR_W'(PAT_N * 8);

    logic [ADDR_W-1:0] off;

    // Purpose: classify the address and compute the table offset.
    always_comb begin
        region = RG_NONE;
        off    = '0;
        if (addr == A_SRST)       region = RG_SRST;
        else if (addr == A_HSIZE) region = RG_HSIZE;
        else if (addr == A_VSIZE) region = RG_VSIZE;
        else if (addr == A_CTRL)  region = RG_CTRL;
        else if (addr == A_TOP)   region = RG_TOP;
        else if (addr == A_CPOS)  region = RG_CPOS;
        else if (addr >= A_CPAL && addr < CPAL_END) begin
            region = RG_CPAL;
            off    = addr - A_CPAL;
        end else if (addr >= A_PAL && addr < PAL_END) begin
            region = RG_PAL;
            off    = addr - A_PAL;
        end else if (addr >= A_PAT && addr < PAT_END) begin
            region = RG_PAT;
            off    = addr - A_PAT;
        end
    end

    assign idx = off[IDX_W+2:3];
endmodule

// File: rtl/dispctl_depth.sv
// Depth decoder: converts the 3-bit depth code into a pixel width in bits
// and a supported flag. Codes above 5 are unsupported and yield zero.
module dispctl_depth (
    input  logic [2:0] code,
    output logic [4:0] bits,
    output logic       ok
);
    // Purpose: code-to-width lookup.
    always_comb begin
        ok = 1'b1;
        case (code)
            3'd0:    bits = 5'd1;
            3'd1:    bits = 5'd2;
            3'd2:    bits = 5'd4;
            3'd3:    bits = 5'd8;
            3'd4:    bits = 5'd15;
            3'd5:    bits = 5'd16;
            default: begin bits = 5'd0; ok = 1'b0; end
        endcase
    end
endmodule

// File: rtl/dispctl_table.sv
// Flop-based lookup table with one write port, one bus read port and one
// combinational lookup port. Clears fully on reset or on 'clear'.
// BUS_READ=0 makes the table write-only from the bus (reads give zero).
// Assumes indices outside ENTRIES are filtered by the decoder.
module dispctl_table #(
    parameter int ENTRIES  = 256,
    parameter int DATA_W   = 24,
    parameter bit BUS_READ = 1'b1,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IW-1:0]     ridx,
    output logic [DATA_W-1:0] rdata,
    input  logic [IW-1:0]     lidx,
    output logic [DATA_W-1:0] ldata
);
    logic [DATA_W-1:0] mem [ENTRIES];

    // Purpose: storage update with whole-table clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we && int'(widx) < ENTRIES) begin
            mem[widx] <= wdata;
        end
    end

    // Purpose: pixel-side lookup.
    assign ldata = (int'(lidx) < ENTRIES) ? mem[lidx] : '0;

    generate
        if (BUS_READ) begin : g_rd
            assign rdata = (int'(ridx) < ENTRIES) ? mem[ridx] : '0;
        end else begin : g_nord
            logic ridx_unused;
            assign ridx_unused = ^ridx;
            assign rdata = '0;
        end
    endgenerate
endmodule

// File: rtl/dispctl_regs.sv
// Display controller register file (top). Decodes word accesses, keeps the
// scalar configuration registers, owns three lookup tables, answers every
// request one cycle later and manages the frame interrupt.
// Assumes word-aligned byte addresses and a single outstanding access.
module dispctl_regs
    import dispctl_pkg::*;
#(
    parameter int  WID_W   = 12,
    parameter int  HGT_W   = 12,
    parameter int  TOP_W   = 24,
    parameter int  COORD_W = 12,
    parameter int  PAL_N   = 256,
    parameter int  CPAL_N  = 3,
    parameter int  PAT_N   = 512,
    parameter int  PAT_W   = 16,
    localparam int PAL_IW  = $clog2(PAL_N),
    localparam int CPAL_IW = $clog2(CPAL_N),
    localparam int PAT_IW  = $clog2(PAT_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         req_wdata,
    input  logic                frame_done,
    output logic                rsp_ready,
    output logic [31:0]         rsp_rdata,
    output logic                irq,
    output logic [WID_W-1:0]    cfg_width,
    output logic [HGT_W-1:0]    cfg_height,
    output logic [TOP_W-1:0]    cfg_top,
    output logic                cfg_blank,
    output logic                cfg_cursor_on,
    output logic [4:0]          cfg_depth_bits,
    output logic                cfg_depth_ok,
    output logic [COORD_W-1:0]  cursor_x,
    output logic [COORD_W-1:0]  cursor_y,
    input  logic [PAL_IW-1:0]   pix_index,
    output logic [23:0]         pix_rgb,
    input  logic [CPAL_IW-1:0]  cur_sel,
    output logic [23:0]         cur_rgb,
    input  logic [PAT_IW-1:0]   pat_row,
    output logic [PAT_W-1:0]    pat_word
);
    localparam int IDX_A = (PAL_IW > CPAL_IW) ? PAL_IW : CPAL_IW;
    localparam int IDX_W = (PAT_IW > IDX_A) ? PAT_IW : IDX_A;

    region_t            region;
    logic [IDX_W-1:0]   idx;
    logic               wr, rd, soft_rst;
    logic [WID_W-1:0]   width_q;
    logic [HGT_W-1:0]   height_q;
    logic [31:0]        ctrl_q;
    logic [TOP_W-1:0]   top_q;
    logic [2*COORD_W-1:0] cpos_q;
    logic               irq_q;
    logic               ready_q;
    logic [31:0]        rdata_q;
    logic [31:0]        rd_mux;
    logic [23:0]        pal_rd, cpal_rd;
    logic [PAT_W-1:0]   pat_rd;

    dispctl_decode #(
        .CPAL_N(CPAL_N), .PAL_N(PAL_N), .PAT_N(PAT_N), .IDX_W(IDX_W)
    ) u_dec (
        .addr(req_addr), .region(region), .idx(idx)
    );

    assign wr       = req_valid && req_write;
    assign rd       = req_valid && !req_write;
    assign soft_rst = wr && (region == RG_SRST);

    // Purpose: scalar configuration registers, cleared by reset or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            width_q  <= '0;
            height_q <= '0;
            ctrl_q   <= '0;
            top_q    <= '0;
            cpos_q   <= '0;
        end else if (wr) begin
            case (region)
                RG_HSIZE: width_q  <= {req_wdata[WID_W-3:0], 2'b00};
                RG_VSIZE: height_q <= req_wdata[HGT_W:1];
                RG_CTRL:  ctrl_q   <= req_wdata;
                RG_TOP:   top_q    <= req_wdata[TOP_W-1:0];
                RG_CPOS:  cpos_q   <= req_wdata[2*COORD_W-1:0];
                default:  ;
            endcase
        end
    end

    // Purpose: frame interrupt; any write clears and wins over a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_q <= 1'b0;
        else if (wr)         irq_q <= 1'b0;
        else if (frame_done) irq_q <= 1'b1;
    end

    dispctl_table #(.ENTRIES(PAL_N), .DATA_W(24), .BUS_READ(1'b0)) u_pal (
        .clk(clk), .rst_n(rst_n), .clear(soft_rst),
        .we(wr && region == RG_PAL), .widx(idx[PAL_IW-1:0]),
        .wdata(req_wdata[23:0]), .ridx(idx[PAL_IW-1:0]), .rdata(pal_rd),
        .lidx(pix_index), .ldata(pix_rgb)
    );

    dispctl_table #(.ENTRIES(CPAL_N), .DATA_W(24), .BUS_READ(1'b1)) u_cpal (
        .clk(clk), .rst_n(rst_n), .clear(soft_rst),
        .we(wr && region == RG_CPAL), .widx(idx[CPAL_IW-1:0]),
        .wdata(req_wdata[23:0]), .ridx(idx[CPAL_IW-1:0]), .rdata(cpal_rd),
        .lidx(cur_sel), .ldata(cur_rgb)
    );

    dispctl_table #(.ENTRIES(PAT_N), .DATA_W(PAT_W), .BUS_READ(1'b1)) u_pat (
        .clk(clk), .rst_n(rst_n), .clear(soft_rst),
        .we(wr && region == RG_PAT), .widx(idx[PAT_IW-1:0]),
        .wdata(req_wdata[PAT_W-1:0]), .ridx(idx[PAT_IW-1:0]), .rdata(pat_rd),
        .lidx(pat_row), .ldata(pat_word)
    );

    dispctl_depth u_depth (
        .code(ctrl_q[CTL_DEPTH+2:CTL_DEPTH]),
        .bits(cfg_depth_bits), .ok(cfg_depth_ok)
    );

    // Purpose: read data selection with geometry rescaling.
    always_comb begin
        case (region)
            RG_HSIZE: rd_mux = 32'(width_q[WID_W-1:2]);
            RG_VSIZE: rd_mux = 32'({height_q, 1'b0});
            RG_CTRL:  rd_mux = ctrl_q;
            RG_CPAL:  rd_mux = 32'(cpal_rd);
            RG_PAL:   rd_mux = 32'(pal_rd);
            RG_PAT:   rd_mux = 32'(pat_rd);
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: one-cycle response stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= req_valid;
            rdata_q <= rd ? rd_mux : '0;
        end
    end

    assign rsp_ready     = ready_q;
    assign rsp_rdata     = rdata_q;
    assign irq           = irq_q;
    assign cfg_width     = width_q;
    assign cfg_height    = height_q;
    assign cfg_top       = top_q;
    assign cfg_blank     = ctrl_q[CTL_BLANK];
    assign cfg_cursor_on = !ctrl_q[CTL_NOCUR];
    assign cursor_x      = cpos_q[2*COORD_W-1:COORD_W];
    assign cursor_y      = cpos_q[COORD_W-1:0];
endmodule

// File: rtl/dispctl_regs_chk.sv
// Protocol and state checker for dispctl_regs, attached by bind.
// Assumes the default address map from dispctl_pkg.
module dispctl_regs_chk
    import dispctl_pkg::*;
#(
    parameter int WID_W = 12,
    parameter int HGT_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              frame_done,
    input logic              rsp_ready,
    input logic [31:0]       rsp_rdata,
    input logic              irq,
    input logic [WID_W-1:0]  cfg_width,
    input logic [HGT_W-1:0]  cfg_height,
    input logic              cfg_blank,
    input logic [4:0]        cfg_depth_bits,
    input logic              cfg_depth_ok
);
    assert_ready_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ready);
    assert_write_rsp_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 32'd0));
    assert_width_scaled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == A_HSIZE)
        |=> (cfg_width == {$past(req_wdata[WID_W-3:0]), 2'b00}));
    assert_depth_consistent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_depth_ok == (cfg_depth_bits != 5'd0));
    assert_irq_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !irq);
    assert_irq_raised_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !(req_valid && req_write)) |=> irq);
    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == A_SRST)
        |=> (cfg_width == '0 && cfg_height == '0 && !cfg_blank && !irq));
endmodule

bind dispctl_regs dispctl_regs_chk #(.WID_W(WID_W), .HGT_W(HGT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .frame_done(frame_done),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_blank(cfg_blank),
    .cfg_depth_bits(cfg_depth_bits), .cfg_depth_ok(cfg_depth_ok)
);

// File: tb/sim_dispctl_regs.sv
module sim_dispctl_regs;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        frame_done = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata;
    logic        irq;
    logic [11:0] cfg_width, cfg_height;
    logic [23:0] cfg_top;
    logic        cfg_blank, cfg_cursor_on, cfg_depth_ok;
    logic [4:0]  cfg_depth_bits;
    logic [11:0] cursor_x, cursor_y;
    logic [7:0]  pix_index = '0;
    logic [23:0] pix_rgb;
    logic [1:0]  cur_sel = '0;
    logic [23:0] cur_rgb;
    logic [8:0]  pat_row = '0;
    logic [15:0] pat_word;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    dispctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .frame_done(frame_done),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_top(cfg_top),
        .cfg_blank(cfg_blank), .cfg_cursor_on(cfg_cursor_on),
        .cfg_depth_bits(cfg_depth_bits), .cfg_depth_ok(cfg_depth_ok),
        .cursor_x(cursor_x), .cursor_y(cursor_y),
        .pix_index(pix_index), .pix_rgb(pix_rgb), .cur_sel(cur_sel), .cur_rgb(cur_rgb),
        .pat_row(pat_row), .pat_word(pat_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [20:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk("R1 write ready", 32'(rsp_ready), 1);
        chk("R1 write data zero", rsp_rdata, 0);
    endtask

    task automatic bus_rd(input logic [20:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk("R1 read ready", 32'(rsp_ready), 1);
        d = rsp_rdata;
    endtask

    function automatic logic [23:0] pal_val(input int i);
        return {8'(i), 8'(~i), 8'(i ^ 8'h5A)};
    endfunction

    function automatic logic [15:0] pat_val(input int i);
        return 16'((i * 37) ^ 16'hBEEF);
    endfunction

    function automatic logic [4:0] depth_of(input int c);
        case (c)
            0: return 5'd1;
            1: return 5'd2;
            2: return 5'd4;
            3: return 5'd8;
            4: return 5'd15;
            5: return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        chk("R13 ready", 32'(rsp_ready), 0);
        chk("R13 irq", 32'(irq), 0);
        chk("R13 width", 32'(cfg_width), 0);
        chk("R13 height", 32'(cfg_height), 0);
        chk("R13 depth", 32'(cfg_depth_bits), 1);
        chk("R13 depth ok", 32'(cfg_depth_ok), 1);
        chk("R13 cursor on", 32'(cfg_cursor_on), 1);
        chk("R13 palette", 32'(pix_rgb), 0);
        chk("R1 idle", 32'(rsp_ready), 0);

        // R2 width sweep incl. truncation
        for (int v = 0; v < 1100; v += 37) begin
            logic [31:0] w;
            w = 32'((v * 4) & 32'hFFF);
            bus_wr(21'h000100, 32'(v));
            chk("R2 width", 32'(cfg_width), w);
            bus_rd(21'h000100, d);
            chk("R2 readback", d, w / 4);
        end
        bus_wr(21'h000100, 32'd1024);
        chk("R2 width wrap", 32'(cfg_width), 0);

        // R3 height sweep incl. truncation
        for (int v = 0; v < 8300; v += 331) begin
            logic [31:0] h;
            h = 32'((v / 2) & 32'hFFF);
            bus_wr(21'h000108, 32'(v));
            chk("R3 height", 32'(cfg_height), h);
            bus_rd(21'h000108, d);
            chk("R3 readback", d, h * 2);
        end

        // R4 / R5 control sweep
        for (int c = 0; c < 8; c++) begin
            logic [31:0] cw;
            cw = (32'(c) << 20) | (32'(c & 1) << 10) | (32'((c >> 1) & 1) << 23) | 32'h5;
            bus_wr(21'h000110, cw);
            chk("R5 depth bits", 32'(cfg_depth_bits), 32'(depth_of(c)));
            chk("R5 depth ok", 32'(cfg_depth_ok), (c < 6) ? 1 : 0);
            chk("R4 blank", 32'(cfg_blank), 32'(c & 1));
            chk("R4 cursor on", 32'(cfg_cursor_on), 32'(((c >> 1) & 1) ^ 1));
            bus_rd(21'h000110, d);
            chk("R4 readback", d, cw);
        end

        // R6 top and cursor position
        bus_wr(21'h000118, 32'h12ABCDEF);
        chk("R6 top", 32'(cfg_top), 32'hABCDEF);
        bus_rd(21'h000118, d);
        chk("R6 top reads zero", d, 0);
        bus_wr(21'h000120, (32'h123 << 12) | 32'h456);
        chk("R6 cursor x", 32'(cursor_x), 32'h123);
        chk("R6 cursor y", 32'(cursor_y), 32'h456);
        bus_rd(21'h000120, d);
        chk("R6 cpos reads zero", d, 0);

        // R7 colour palette, full sweep
        for (int i = 0; i < 256; i++) bus_wr(21'(32'h800 + i * 8), 32'hFF000000 | 32'(pal_val(i)));
        for (int i = 0; i < 256; i++) begin
            pix_index = 8'(i);
            #1;
            chk("R7 palette lookup", 32'(pix_rgb), 32'(pal_val(i)));
        end
        bus_rd(21'h000808, d);
        chk("R7 palette reads zero", d, 0);
        bus_wr(21'h00081C, 32'h00A1B2C3);
        pix_index = 8'd3;
        #1;
        chk("R7 stride offset", 32'(pix_rgb), 32'h00A1B2C3);

        // R8 cursor palette
        for (int i = 0; i < 3; i++) bus_wr(21'(32'h400 + i * 8), 32'(pal_val(i + 100)));
        for (int i = 0; i < 3; i++) begin
            bus_rd(21'(32'h400 + i * 8), d);
            chk("R8 cursor palette read", d, 32'(pal_val(i + 100)));
            cur_sel = 2'(i);
            #1;
            chk("R8 cursor palette lookup", 32'(cur_rgb), 32'(pal_val(i + 100)));
        end

        // R9 cursor pattern, full sweep
        for (int i = 0; i < 512; i++) bus_wr(21'(32'h1000 + i * 8), 32'hFFFF0000 | 32'(pat_val(i)));
        for (int i = 0; i < 512; i++) begin
            bus_rd(21'(32'h1000 + i * 8), d);
            chk("R9 pattern read", d, 32'(pat_val(i)));
        end
        for (int i = 0; i < 512; i += 73) begin
            pat_row = 9'(i);
            #1;
            chk("R9 pattern lookup", 32'(pat_word), 32'(pat_val(i)));
        end

        // R10 interrupt
        @(negedge clk); frame_done = 1;
        @(negedge clk); frame_done = 0;
        chk("R10 irq raised", 32'(irq), 1);
        bus_wr(21'h002000, 32'h0);
        chk("R10 irq cleared by write", 32'(irq), 0);
        @(negedge clk);
        frame_done = 1; req_valid = 1; req_write = 1; req_addr = 21'h000000; req_wdata = 0;
        @(negedge clk);
        frame_done = 0; req_valid = 0; req_write = 0;
        chk("R10 write wins", 32'(irq), 0);

        // R12 ignored and unmapped accesses
        bus_wr(21'h000100, 32'd100);
        bus_wr(21'h000000, 32'hFFFFFFFF);
        bus_wr(21'h0000F8, 32'hFFFFFFFF);
        bus_wr(21'h000128, 32'hFFFFFFFF);
        bus_wr(21'h002000, 32'hFFFFFFFF);
        bus_wr(21'h000418, 32'hFFFFFFFF);
        chk("R12 width kept", 32'(cfg_width), 400);
        chk("R12 top kept", 32'(cfg_top), 32'hABCDEF);
        chk("R12 cursor kept", 32'(cursor_x), 32'h123);
        bus_rd(21'h000110, d);
        chk("R12 ctrl kept", d, (32'd7 << 20) | (32'd1 << 10) | (32'd1 << 23) | 32'h5);
        pix_index = 8'd200;
        #1;
        chk("R12 palette kept", 32'(pix_rgb), 32'(pal_val(200)));
        bus_rd(21'h000000, d);
        chk("R12 timing read zero", d, 0);
        bus_rd(21'h003000, d);
        chk("R12 unmapped read zero", d, 0);

        // R11 soft reset
        @(negedge clk); frame_done = 1;
        @(negedge clk); frame_done = 0;
        bus_wr(21'h100000, 32'h0);
        chk("R11 width", 32'(cfg_width), 0);
        chk("R11 height", 32'(cfg_height), 0);
        chk("R11 top", 32'(cfg_top), 0);
        chk("R11 cursor x", 32'(cursor_x), 0);
        chk("R11 cursor y", 32'(cursor_y), 0);
        chk("R11 irq", 32'(irq), 0);
        chk("R11 depth", 32'(cfg_depth_bits), 1);
        chk("R11 palette", 32'(pix_rgb), 0);
        cur_sel = 2'd1; pat_row = 9'd5;
        #1;
        chk("R11 cursor palette", 32'(cur_rgb), 0);
        chk("R11 pattern", 32'(pat_word), 0);
        bus_rd(21'h000110, d);
        chk("R11 ctrl", d, 0);
        bus_rd(21'h001028, d);
        chk("R11 pattern read", d, 0);
        @(negedge clk);
        chk("R1 idle after", 32'(rsp_ready), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule